// File: doc/BRIEF.md
# Debug ROM Table Walker

This block enumerates the debug components reachable through a ROM table, entirely in hardware. After a start pulse carrying a table address, it checks the table's four identification words and reads the table's memory-type word. It then reads 32-bit table entries one after another until it finds an all-zero entry or reaches a configured entry limit. All reads go through a single 32-bit request/acknowledge read port.

Each entry whose present bit is set names a component at a signed offset from the table base. The walker reads that component's identification registers and derives several values from them: the component base, its start address (the base minus the number of extra 4 KB blocks the component occupies), its class and its 12-bit part number. For components of the debug-component class it also reads a device-type byte. It hands each result to a consumer as one record over a valid/ready handshake and does not continue until the record is taken. Any read error ends the walk and reports the failing address.

Top module: `dbg_rom_walker`

## Requirements
- R1: A start pulse while idle sets the table base to `base_addr` with bits [11:0] cleared. The first four reads go to table base + 0xFF0, 0xFF4, 0xFF8 and 0xFFC, in that order, and every read address has bits [1:0] equal to zero.
- R2: The table preamble is valid only when all of these hold: the byte at 0xFF0 is 0x0D, bits [3:0] of the word at 0xFF4 are zero, the byte at 0xFF8 is 0x05 and the byte at 0xFFC is 0xB1. If it is not valid, the walk ends after the fourth read with `id_bad` = 1, with no further read and no record.
- R3: After a valid preamble, the walker reads table base + 0xFCC, and bit 0 of that word appears on `sysmem` until the next start.
- R4: Entries are read at table base + 0, + 4, + 8 and so on. An entry equal to zero ends the walk (`busy` falls) and produces no record.
- R5: A non-zero entry with bit 0 clear is skipped: it causes no component read and no record, and the walk moves to the next entry.
- R6: For a present entry, the component base is the table base plus entry bits [31:12] × 4096, with those bits taken as a signed two's-complement value and the sum taken modulo 2^ADDR_W. This value is reported on `rec_base`.
- R7: The component reads go to component base + 0xFE0, 0xFE4, 0xFE8, 0xFEC, 0xFD0, 0xFF0, 0xFF4, 0xFF8 and 0xFFC, in that order. `rec_start` is `rec_base` − 4096 × bits [7:4] of the word read at 0xFD0.
- R8: `rec_class` is bits [7:4] of the word read at 0xFF4. `rec_part` is {bits [3:0] of the 0xFE4 word, bits [7:0] of the 0xFE0 word}.
- R9: When the class is 9, one more read goes to component base + 0xFCC and `rec_devtype` is its byte [7:0]. For any other class there is no such read and `rec_devtype` is 0.
- R10: A record holds its fields stable while `rec_valid` is high and `rec_ready` is low. No memory read is issued while a record is pending.
- R11: A read that returns `rd_err` ends the walk: `err` goes to 1, `err_addr` holds the failing address, `busy` falls and no record is produced for that component.
- R12: After ENTRY_MAX entries have been read without a zero entry, the walk ends without reading further entries.
- R13: `rd_req` stays high, with `rd_addr` stable, until a cycle in which `rd_ack` is high.
- R14: A start pulse while `busy` is high has no effect on the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| base_addr | input | ADDR_W | ROM table address, low 12 bits ignored |
| busy | output | 1 | Walk in progress |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read word address |
| rd_ack | input | 1 | Read completion, one cycle |
| rd_data | input | 32 | Read data, valid with rd_ack |
| rd_err | input | 1 | Read failed, valid with rd_ack |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Consumer takes the record |
| rec_base | output | ADDR_W | Component base address |
| rec_start | output | ADDR_W | Component start address |
| rec_class | output | 4 | Component class |
| rec_part | output | 12 | Part number |
| rec_devtype | output | 8 | Device type (class 9 only, else 0) |
| sysmem | output | 1 | System memory present flag from the table |
| id_bad | output | 1 | Table preamble was invalid |
| err | output | 1 | Walk ended on a read error |
| err_addr | output | ADDR_W | Address of the failing read |

## Verification
The bench instantiates the walker with ENTRY_MAX set to 4 and ADDR_W at 32. With only four entries allowed, a table whose first four entries are all non-zero stops on the limit, and the bench can show that the fifth word is never read. The 32-bit address width lets one test use a negative entry offset that places a component below its table. The memory model can add wait cycles before each acknowledge, which holds each request open over several cycles. The consumer can hold `rec_ready` low for stretches, so a record stays pending while the walker must stay quiet.

// File: rtl/drw_pkg.sv
package drw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TID, ST_TMEM, ST_ENT, ST_CID, ST_DEV, ST_LOAD, ST_EMIT
  } drw_state_e;

  localparam logic [11:0] OFF_TYPE   = 12'hFCC;
  localparam logic [11:0] OFF_CID0   = 12'hFF0;
  localparam logic [3:0]  CLASS_DBG  = 4'd9;
  localparam logic [3:0]  LAST_CSTEP = 4'd8;

  // Offset of the n-th component identification read.
  function automatic logic [11:0] comp_off(input logic [3:0] n);
    logic [11:0] o;
    if (n < 4'd4)       o = 12'hFE0 + {6'd0, n, 2'b00};
    else if (n == 4'd4) o = 12'hFD0;
    else                o = 12'hFF0 + {6'd0, n - 4'd5, 2'b00};
    return o;
  endfunction

  // Check of one table preamble word.
  function automatic logic pre_ok(input logic [1:0] n, input logic [7:0] b);
    logic ok;
    case (n)
      2'd0:    ok = (b == 8'h0D);
      2'd1:    ok = (b[3:0] == 4'h0);
      2'd2:    ok = (b == 8'h05);
      default: ok = (b == 8'hB1);
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/drw_id_capture.sv
module drw_id_capture #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic              dev_en,
  input  logic [3:0]        step,
  input  logic [7:0]        data,
  input  logic [ADDR_W-1:0] cbase,
  output logic [3:0]        cls,
  output logic [11:0]       part,
  output logic [7:0]        dev,
  output logic [ADDR_W-1:0] start_addr
);
  import drw_pkg::*;

  logic [7:0] pid0_q;
  logic [3:0] pid1_q;
  logic [3:0] blk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pid0_q <= '0;
      pid1_q <= '0;
      blk_q  <= '0;
      cls    <= '0;
      dev    <= '0;
    end else begin
      if (cap_en) begin
        case (step)
          4'd0: begin pid0_q <= data; dev <= '0; end
          4'd1: pid1_q <= data[3:0];
          4'd4: blk_q  <= data[7:4];
          4'd6: cls    <= data[7:4];
          default: ;
        endcase
      end
      if (dev_en) dev <= data;
    end
  end

  assign part       = {pid1_q, pid0_q};
  assign start_addr = cbase - {{(ADDR_W-16){1'b0}}, blk_q, 12'h000};

  AST_DEV_ONLY_DBG: assert property (@(posedge clk) disable iff (rst)
    dev_en |-> cls == CLASS_DBG); // R9

endmodule

// File: rtl/drw_rec_slot.sv
module drw_rec_slot #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [ADDR_W-1:0] in_start,
  input  logic [3:0]        in_class,
  input  logic [11:0]       in_part,
  input  logic [7:0]        in_dev,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] start,
  output logic [3:0]        cls,
  output logic [11:0]       part,
  output logic [7:0]        dev
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      base  <= '0;
      start <= '0;
      cls   <= '0;
      part  <= '0;
      dev   <= '0;
    end else if (load) begin
      valid <= 1'b1;
      base  <= in_base;
      start <= in_start;
      cls   <= in_class;
      part  <= in_part;
      dev   <= in_dev;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  AST_REC_HOLD: assert property (@(posedge clk) disable iff (rst)
    valid && !ready |=> valid && $stable(base) && $stable(start)
                        && $stable(part) && $stable(dev)); // R10

endmodule

// File: rtl/dbg_rom_walker.sv
module dbg_rom_walker #(
  parameter int ADDR_W    = 32,
  parameter int ENTRY_MAX = 960
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              busy,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [31:0]       rd_data,
  input  logic              rd_err,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [ADDR_W-1:0] rec_base,
  output logic [ADDR_W-1:0] rec_start,
  output logic [3:0]        rec_class,
  output logic [11:0]       rec_part,
  output logic [7:0]        rec_devtype,
  output logic              sysmem,
  output logic              id_bad,
  output logic              err,
  output logic [ADDR_W-1:0] err_addr
);
  import drw_pkg::*;

  localparam int ENT_W = $clog2(ENTRY_MAX + 1);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(12'hFFF);

  drw_state_e        state;
  logic [3:0]        step;
  logic [ENT_W-1:0]  ent;
  logic [ADDR_W-1:0] tbase, cbase;
  logic              pre_good;

  logic              acc, cap_en, dev_en, load_rec;
  logic [ENT_W-1:0]  ent_nx;
  logic              ent_last;
  logic [ADDR_W-1:0] ent_next_addr, eoff, new_cbase;
  logic [3:0]        cap_cls;
  logic [11:0]       cap_part;
  logic [7:0]        cap_dev;
  logic [ADDR_W-1:0] cap_start;

  always_comb begin
    acc           = rd_req && rd_ack;
    cap_en        = acc && !rd_err && (state == ST_CID);
    dev_en        = acc && !rd_err && (state == ST_DEV);
    load_rec      = (state == ST_LOAD);
    ent_nx        = ent + 1'b1;
    ent_last      = (ent_nx == ENT_W'(ENTRY_MAX));
    ent_next_addr = tbase + (ADDR_W'(ent_nx) << 2);
    eoff          = {{(ADDR_W-20){rd_data[31]}}, rd_data[31:12]} << 12;
    new_cbase     = tbase + eoff;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      step     <= '0;
      ent      <= '0;
      tbase    <= '0;
      cbase    <= '0;
      pre_good <= 1'b0;
      busy     <= 1'b0;
      rd_req   <= 1'b0;
      rd_addr  <= '0;
      sysmem   <= 1'b0;
      id_bad   <= 1'b0;
      err      <= 1'b0;
      err_addr <= '0;
    end else if (state == ST_IDLE) begin
      if (start) begin
        tbase    <= base_addr & ~LOW_MASK;
        rd_addr  <= {base_addr[ADDR_W-1:12], OFF_CID0};
        rd_req   <= 1'b1;
        busy     <= 1'b1;
        step     <= '0;
        ent      <= '0;
        pre_good <= 1'b1;
        sysmem   <= 1'b0;
        id_bad   <= 1'b0;
        err      <= 1'b0;
        err_addr <= '0;
        state    <= ST_TID;
      end
    end else if (acc && rd_err) begin
      err      <= 1'b1;
      err_addr <= rd_addr;
      rd_req   <= 1'b0;
      busy     <= 1'b0;
      state    <= ST_IDLE;
    end else begin
      case (state)
        ST_TID: if (acc) begin
          if (step == 4'd3) begin
            if (pre_good && pre_ok(step[1:0], rd_data[7:0])) begin
              rd_addr <= {tbase[ADDR_W-1:12], OFF_TYPE};
              state   <= ST_TMEM;
            end else begin
              id_bad <= 1'b1;
              rd_req <= 1'b0;
              busy   <= 1'b0;
              state  <= ST_IDLE;
            end
          end else begin
            pre_good <= pre_good && pre_ok(step[1:0], rd_data[7:0]);
            step     <= step + 1'b1;
            rd_addr  <= {tbase[ADDR_W-1:12], OFF_CID0 + {6'd0, step + 1'b1, 2'b00}};
          end
        end
        ST_TMEM: if (acc) begin
          sysmem  <= rd_data[0];
          rd_addr <= tbase;
          state   <= ST_ENT;
        end
        ST_ENT: if (acc) begin
          if (rd_data == 32'd0) begin
            rd_req <= 1'b0;
            busy   <= 1'b0;
            state  <= ST_IDLE;
          end else if (rd_data[0]) begin
            cbase   <= new_cbase;
            rd_addr <= {new_cbase[ADDR_W-1:12], comp_off(4'd0)};
            step    <= '0;
            state   <= ST_CID;
          end else if (ent_last) begin
            rd_req <= 1'b0;
            busy   <= 1'b0;
            state  <= ST_IDLE;
          end else begin
            ent     <= ent_nx;
            rd_addr <= ent_next_addr;
          end
        end
        ST_CID: if (acc) begin
          if (step == LAST_CSTEP) begin
            if (cap_cls == CLASS_DBG) begin
              rd_addr <= {cbase[ADDR_W-1:12], OFF_TYPE};
              state   <= ST_DEV;
            end else begin
              rd_req <= 1'b0;
              state  <= ST_LOAD;
            end
          end else begin
            step    <= step + 1'b1;
            rd_addr <= {cbase[ADDR_W-1:12], comp_off(step + 1'b1)};
          end
        end
        ST_DEV: if (acc) begin
          rd_req <= 1'b0;
          state  <= ST_LOAD;
        end
        ST_LOAD: state <= ST_EMIT;
        ST_EMIT: if (rec_valid && rec_ready) begin
          if (ent_last) begin
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            ent     <= ent_nx;
            rd_addr <= ent_next_addr;
            rd_req  <= 1'b1;
            state   <= ST_ENT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  drw_id_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst(rst), .cap_en(cap_en), .dev_en(dev_en), .step(step),
    .data(rd_data[7:0]), .cbase(cbase), .cls(cap_cls), .part(cap_part),
    .dev(cap_dev), .start_addr(cap_start)
  );

  drw_rec_slot #(.ADDR_W(ADDR_W)) u_slot (
    .clk(clk), .rst(rst), .load(load_rec), .in_base(cbase), .in_start(cap_start),
    .in_class(cap_cls), .in_part(cap_part), .in_dev(cap_dev), .ready(rec_ready),
    .valid(rec_valid), .base(rec_base), .start(rec_start), .cls(rec_class),
    .part(rec_part), .dev(rec_devtype)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr)); // R13
  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> rd_addr[1:0] == 2'b00); // R1
  AST_QUIET_PENDING: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> !rd_req); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rd_req && !rec_valid); // R11
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> !busy); // R11
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> $stable(tbase)); // R14

endmodule

// File: tb/tb_dbg_rom_walker.sv
module tb_dbg_rom_walker;
  localparam int AW = 32;
  localparam int EMAX = 4;

  typedef struct packed {
    logic [31:0] base; logic [31:0] start;
    logic [3:0] cls; logic [11:0] part; logic [7:0] dev;
  } rec_t;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, rd_ack = 1'b0, rd_err = 1'b0, rec_ready = 1'b1;
  logic [31:0] base_addr = '0, rd_data = '0;
  logic busy, rd_req, rec_valid, sysmem, id_bad, err;
  logic [31:0] rd_addr, rec_base, rec_start, err_addr;
  logic [3:0] rec_class; logic [11:0] rec_part; logic [7:0] rec_devtype;

  always #5 clk = ~clk;

  dbg_rom_walker #(.ADDR_W(AW), .ENTRY_MAX(EMAX)) dut (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .busy(busy),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .rd_err(rd_err), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_base(rec_base), .rec_start(rec_start), .rec_class(rec_class),
    .rec_part(rec_part), .rec_devtype(rec_devtype), .sysmem(sysmem),
    .id_bad(id_bad), .err(err), .err_addr(err_addr)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, lat = 0, wc = 0;
  bit stall = 0, inj_en = 0, finished = 0;
  logic [31:0] inj_addr = '0, held = '0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_addr[$];
  string       exp_tag[$];
  rec_t        exp_rec[$];
  bit exp_idbad, exp_err, exp_sys;
  logic [31:0] exp_err_addr;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, expv);
    end
  endtask

  function automatic logic [31:0] rdm(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'd0;
  endfunction

  // Reference walk, written from the requirements.
  task automatic mread(input logic [31:0] a, input string tag, output bit bad, output logic [31:0] d);
    exp_addr.push_back(a); exp_tag.push_back(tag);
    bad = inj_en && (a == inj_addr);
    if (bad) begin exp_err = 1; exp_err_addr = a; end
    d = rdm(a);
  endtask

  task automatic model_walk(input logic [31:0] base);
    logic [31:0] tb_, d, e, cb; bit bad, ok; rec_t r;
    logic [31:0] w[9];
    logic [11:0] offs[9] = '{12'hFE0, 12'hFE4, 12'hFE8, 12'hFEC, 12'hFD0,
                             12'hFF0, 12'hFF4, 12'hFF8, 12'hFFC};
    exp_idbad = 0; exp_err = 0; exp_sys = 0; exp_err_addr = 0;
    tb_ = {base[31:12], 12'h000}; ok = 1;
    for (int k = 0; k < 4; k++) begin
      mread(tb_ | (32'hFF0 + 32'(4*k)), "R1", bad, d);
      if (bad) return;
      case (k)
        0: ok &= (d[7:0] == 8'h0D);
        1: ok &= (d[3:0] == 4'h0);
        2: ok &= (d[7:0] == 8'h05);
        default: ok &= (d[7:0] == 8'hB1);
      endcase
    end
    if (!ok) begin exp_idbad = 1; return; end
    mread(tb_ | 32'hFCC, "R3", bad, d);
    if (bad) return;
    exp_sys = d[0];
    for (int i = 0; i < EMAX; i++) begin
      mread(tb_ + 32'(4*i), "R4", bad, e);
      if (bad || e == 0) return;
      if (!e[0]) continue;
      cb = tb_ + {e[31:12], 12'h000};
      for (int k = 0; k < 9; k++) begin
        mread({cb[31:12], offs[k]}, "R7", bad, w[k]);
        if (bad) return;
      end
      r.base = cb; r.start = cb - {16'd0, w[4][7:4], 12'h000};
      r.cls = w[6][7:4]; r.part = {w[1][3:0], w[0][7:0]}; r.dev = 8'h00;
      if (r.cls == 4'd9) begin
        mread({cb[31:12], 12'hFCC}, "R9", bad, d);
        if (bad) return;
        r.dev = d[7:0];
      end
      exp_rec.push_back(r);
    end
  endtask

  // Memory model with programmable wait cycles.
  always @(negedge clk) begin
    cyc++;
    if (rd_ack) begin
      rd_ack = 0; rd_err = 0;
    end else if (rd_req && !rst) begin
      if (wc == 0) held = rd_addr;
      else chk(rd_addr == held, "R13 address held", rd_addr, held);
      if (wc >= lat) begin
        wc = 0;
        if (exp_addr.size() == 0) chk(0, "R4 unexpected read", rd_addr, 0);
        else begin
          string t; logic [31:0] ea;
          ea = exp_addr.pop_front(); t = exp_tag.pop_front();
          chk(rd_addr == ea, {t, " read address"}, rd_addr, ea);
        end
        rd_data = rdm(rd_addr);
        rd_err = inj_en && (rd_addr == inj_addr);
        rd_ack = 1;
      end else wc++;
    end
  end

  // Record monitor and consumer.
  always @(negedge clk) begin
    rec_ready = !stall || (cyc % 3 == 0);
    if (rec_valid && !rst) begin
      chk(!rd_req, "R10 no read while record pending", {31'd0, rd_req}, 0);
      if (rec_ready) begin
        if (exp_rec.size() == 0) chk(0, "R5 unexpected record", rec_base, 0);
        else begin
          rec_t r; r = exp_rec.pop_front();
          chk(rec_base == r.base, "R6 base", rec_base, r.base);
          chk(rec_start == r.start, "R7 start", rec_start, r.start);
          chk({rec_class, rec_part} == {r.cls, r.part}, "R8 class/part",
              {16'd0, rec_class, rec_part}, {16'd0, r.cls, r.part});
          chk(rec_devtype == r.dev, "R9 devtype", {24'd0, rec_devtype}, {24'd0, r.dev});
        end
      end
    end
  end

  task automatic put(input logic [31:0] a, input logic [31:0] d); mem[a] = d; endtask
  task automatic mk_tab(input logic [31:0] t, input logic [31:0] mt);
    put(t | 32'hFF0, 32'h0D); put(t | 32'hFF4, 32'h10);
    put(t | 32'hFF8, 32'h05); put(t | 32'hFFC, 32'hB1); put(t | 32'hFCC, mt);
  endtask
  task automatic mk_comp(input logic [31:0] c, input logic [7:0] p0, p1, p4, c1, dv);
    put(c | 32'hFE0, {24'd0, p0}); put(c | 32'hFE4, {24'd0, p1}); put(c | 32'hFD0, {24'd0, p4});
    put(c | 32'hFF0, 32'h0D); put(c | 32'hFF4, {24'd0, c1});
    put(c | 32'hFF8, 32'h05); put(c | 32'hFFC, 32'hB1); put(c | 32'hFCC, {24'd0, dv});
  endtask

  task automatic run(input logic [31:0] base, input string rq, input bit poke);
    int n;
    model_walk(base);
    @(negedge clk); base_addr = base; start = 1;
    @(negedge clk); start = 0; base_addr = 32'h0004_0000;
    n = 0;
    while (busy && n < 5000) begin
      @(negedge clk); n++;
      start = poke && (n == 10);
    end
    start = 0;
    chk(n < 5000, {rq, " walk ended"}, n, 5000);
    repeat (4) @(negedge clk);
    chk(exp_addr.size() == 0, {rq, " all reads seen"}, exp_addr.size(), 0);
    chk(exp_rec.size() == 0, {rq, " all records seen"}, exp_rec.size(), 0);
    chk(id_bad == exp_idbad, "R2 id_bad", id_bad, exp_idbad);
    chk(err == exp_err, "R11 err", err, exp_err);
    chk(err_addr == exp_err_addr, "R11 err_addr", err_addr, exp_err_addr);
    chk(sysmem == exp_sys, "R3 sysmem", sysmem, exp_sys);
    exp_addr.delete(); exp_tag.delete(); exp_rec.delete(); mem.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !rd_req && !rec_valid, "R4 reset quiet", {busy, rd_req, rec_valid}, 0);
    chk(!err && !id_bad && !sysmem, "R11 reset flags", {err, id_bad, sysmem}, 0);
    rst = 0;
    @(negedge clk);
    // Present, skipped, negative-offset and zero entries; slow consumer; start while busy.
    mk_tab(32'h0001_0000, 32'h1);
    put(32'h0001_0000, 32'h0000_1003); put(32'h0001_0004, 32'h0000_2002);
    put(32'h0001_0008, 32'hFFFF_F003);
    mk_comp(32'h0001_1000, 8'h23, 8'hB4, 8'h10, 8'h90, 8'h13);
    mk_comp(32'h0000_F000, 8'h0C, 8'h07, 8'h30, 8'h10, 8'h55);
    put(32'h0004_0FF8, 32'h06);
    stall = 1; lat = 0;
    run(32'h0001_0ABC, "R14", 1);
    // Invalid preamble.
    stall = 0; lat = 1;
    mk_tab(32'h0004_0000, 32'h1); put(32'h0004_0FF8, 32'h06);
    run(32'h0004_0000, "R2", 0);
    // Read error on a component read.
    lat = 2; inj_en = 1; inj_addr = 32'h0003_1FD0;
    mk_tab(32'h0003_0000, 32'h1); put(32'h0003_0000, 32'h0000_1003);
    mk_comp(32'h0003_1000, 8'h11, 8'h02, 8'h00, 8'hF0, 8'h00);
    run(32'h0003_0000, "R11", 0);
    inj_en = 0;
    // Entry limit with no zero entry.
    lat = 0; stall = 1;
    mk_tab(32'h0002_0000, 32'h0);
    put(32'h0002_0000, 32'h1002); put(32'h0002_0004, 32'h2002);
    put(32'h0002_0008, 32'h3003); put(32'h0002_000C, 32'h4002);
    put(32'h0002_0010, 32'h5003);
    mk_comp(32'h0002_3000, 8'hAA, 8'h05, 8'h00, 8'hF0, 8'h00);
    run(32'h0002_0000, "R12", 0);
    // Empty table with memory-type bit clear.
    stall = 0;
    mk_tab(32'h0005_0000, 32'h0);
    run(32'h0005_0000, "R5", 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule